// File: doc/BRIEF.md
# DMA Request Router with Fixed-Priority Bus Arbitration

This block sits between twelve peripherals and twelve DMA channels. Every channel holds a 4-bit map value that names the peripheral feeding it. The peripheral's DMA request is steered onto that channel, and its DMA interrupt request is steered onto the channel's bit of the interrupt output vector. Software rewrites the map through a simple write port, so a peripheral can be given a more or less urgent channel.

Requests from all live channels compete for one shared system bus. A fixed-priority arbiter picks the lowest-numbered requesting channel in each cycle in which the bus is idle. It returns a one-cycle grant both to that channel and, as a one-hot pulse, to the peripheral the channel was mapped to when it was picked. A map code that names no peripheral switches a channel off completely. When two or more channels name the same peripheral, only the highest-numbered of them stays connected.

Top module: `dma_periph_router`

## Requirements
- R1: After reset, channel n maps to peripheral n for every n from 0 to 11, and both grant outputs are zero.
- R2: When several live channels request in an idle cycle, the grant goes to the one with the lowest channel index.
- R3: A channel whose map value is 12, 13, 14 or 15 is disabled. It never receives a grant and its irq_out bit stays 0 whatever its peripheral does.
- R4: When several channels hold the same valid map value, only the channel with the highest index is connected. The others behave as disabled.
- R5: Grants are registered. A request presented before a clock edge with bus_busy low gives a chan_gnt pulse after that edge, and at most one chan_gnt bit is set in any cycle.
- R6: While bus_busy is high before an edge, both grant outputs are zero after that edge.
- R7: periph_gnt has the bit of the peripheral mapped to the granted channel set, in the same cycle as chan_gnt. It is zero when chan_gnt is zero.
- R8: irq_out[c] equals periph_irq[p] without a clock delay, where p is the map value of a connected channel c.
- R9: A write with map_we high and map_idx 0 to 11 loads map_val into that channel's map at the clock edge. It affects arbitration from the next cycle on and not the grant decided at that edge. A write with map_idx 12 to 15 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Map write strobe |
| map_idx | input | 4 | Channel whose map is written |
| map_val | input | 4 | New peripheral code for that channel |
| periph_req | input | 12 | DMA request line of each peripheral |
| periph_irq | input | 12 | DMA interrupt request of each peripheral |
| bus_busy | input | 1 | Shared bus is occupied; hold off grants |
| chan_gnt | output | 12 | One-cycle grant to the winning channel |
| periph_gnt | output | 12 | One-cycle grant to the peripheral behind the winning channel |
| irq_out | output | 12 | Interrupt requests forwarded per channel |

## Verification
A corrupted map entry shows on irq_out as soon as the affected peripheral raises its interrupt, with no clock delay. It shows on the grant outputs one edge after that peripheral requests on an idle bus. A wrong duplicate or invalid-code decision shows in the same way: a grant or interrupt appears on a channel that should be dead, or goes missing from the surviving one. A fault in the arbiter or the grant register shows one edge after any idle-bus request, as a wrong winner, a second set bit, or a peripheral grant that does not match the channel grant.

// File: rtl/dma_periph_router.sv
module dma_periph_router #(
  parameter int NUM_CH     = 12,
  parameter int NUM_PERIPH = 12,
  parameter int MAP_W      = 4,
  parameter int IDX_W      = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  map_we,
  input  logic [IDX_W-1:0]      map_idx,
  input  logic [MAP_W-1:0]      map_val,
  input  logic [NUM_PERIPH-1:0] periph_req,
  input  logic [NUM_PERIPH-1:0] periph_irq,
  input  logic                  bus_busy,
  output logic [NUM_CH-1:0]     chan_gnt,
  output logic [NUM_PERIPH-1:0] periph_gnt,
  output logic [NUM_CH-1:0]     irq_out
);

  localparam logic [IDX_W:0] CH_LIM  = (IDX_W+1)'(NUM_CH);
  localparam logic [MAP_W:0] PER_LIM = (MAP_W+1)'(NUM_PERIPH);

  logic [MAP_W-1:0]      map_q [NUM_CH];
  logic [NUM_CH-1:0]     live;
  logic [NUM_CH-1:0]     chan_req;
  logic [NUM_CH-1:0]     win_oh;
  logic [NUM_PERIPH-1:0] win_per;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) map_q[i] <= MAP_W'(i);
    end else if (map_we && ({1'b0, map_idx} < CH_LIM)) begin
      map_q[map_idx] <= map_val;
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      logic shadowed;
      shadowed = 1'b0;
      for (int j = c + 1; j < NUM_CH; j++)
        if (map_q[j] == map_q[c]) shadowed = 1'b1;
      live[c]     = ({1'b0, map_q[c]} < PER_LIM) && !shadowed;
      chan_req[c] = live[c] && periph_req[map_q[c]];
      irq_out[c]  = live[c] && periph_irq[map_q[c]];
    end
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    win_oh  = '0;
    win_per = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chan_req[c] && !found) begin
        found            = 1'b1;
        win_oh[c]        = 1'b1;
        win_per[map_q[c]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bus_busy) begin
      chan_gnt   <= '0;
      periph_gnt <= '0;
    end else begin
      chan_gnt   <= win_oh;
      periph_gnt <= win_per;
    end
  end

endmodule

module dma_periph_router_chk #(
  parameter int NUM_CH     = 12,
  parameter int NUM_PERIPH = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PERIPH-1:0] periph_req,
  input logic [NUM_PERIPH-1:0] periph_irq,
  input logic                  bus_busy,
  input logic [NUM_CH-1:0]     chan_gnt,
  input logic [NUM_PERIPH-1:0] periph_gnt,
  input logic [NUM_CH-1:0]     irq_out
);

  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_gnt));

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> (chan_gnt == '0 && periph_gnt == '0));

  a_r7_periph_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(periph_gnt) && ($countones(periph_gnt) == $countones(chan_gnt)));

  a_r5_grant_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_gnt) |-> $past((|periph_req) && !bus_busy));

  a_r4_irq_no_fanout: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(periph_irq));

endmodule

bind dma_periph_router dma_periph_router_chk #(
  .NUM_CH(NUM_CH), .NUM_PERIPH(NUM_PERIPH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .periph_irq(periph_irq),
  .bus_busy(bus_busy), .chan_gnt(chan_gnt), .periph_gnt(periph_gnt),
  .irq_out(irq_out)
);

// File: tb/dma_periph_router_tb.sv
module dma_periph_router_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_we = 1'b0;
  logic [3:0]  map_idx = '0;
  logic [3:0]  map_val = '0;
  logic [11:0] periph_req = '0;
  logic [11:0] periph_irq = '0;
  logic        bus_busy = 1'b0;
  logic [11:0] chan_gnt, periph_gnt, irq_out;

  int checks = 0;
  int fails  = 0;
  logic [3:0] m [12];

  always #5 clk = ~clk;

  dma_periph_router u_dut (
    .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_idx(map_idx),
    .map_val(map_val), .periph_req(periph_req), .periph_irq(periph_irq),
    .bus_busy(bus_busy), .chan_gnt(chan_gnt), .periph_gnt(periph_gnt),
    .irq_out(irq_out)
  );

  // {req, busy, expected chan_gnt} under the reset map (periph_gnt equal)
  localparam logic [24:0] VEC [8] = '{
    {12'h000, 1'b0, 12'h000},
    {12'h001, 1'b0, 12'h001},
    {12'h800, 1'b0, 12'h800},
    {12'h810, 1'b0, 12'h010},
    {12'hFFF, 1'b1, 12'h000},
    {12'h0C0, 1'b0, 12'h040},
    {12'hA00, 1'b0, 12'h200},
    {12'hFFE, 1'b0, 12'h002}
  };

  task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    map_we = 1'b0;
    periph_req = '0;
    periph_irq = '0;
    bus_busy = 1'b0;
    step();
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) m[i] = 4'(i);
  endtask

  function automatic logic [11:0] model_live();
    logic [11:0] lv;
    for (int c = 0; c < 12; c++) begin
      lv[c] = (m[c] < 4'd12);
      for (int j = c + 1; j < 12; j++) if (m[j] == m[c]) lv[c] = 1'b0;
    end
    return lv;
  endfunction

  function automatic logic [11:0] model_irq(input logic [11:0] irq);
    logic [11:0] lv, r;
    lv = model_live();
    r = '0;
    for (int c = 0; c < 12; c++) if (lv[c] && irq[m[c]]) r[c] = 1'b1;
    return r;
  endfunction

  function automatic logic [23:0] model_gnt(input logic [11:0] req, input logic busy);
    logic [11:0] lv, cg, pg;
    lv = model_live();
    cg = '0;
    pg = '0;
    if (!busy) begin
      for (int c = 11; c >= 0; c--) begin
        if (lv[c] && req[m[c]]) begin
          cg = '0;
          pg = '0;
          cg[c] = 1'b1;
          pg[m[c]] = 1'b1;
        end
      end
    end
    return {pg, cg};
  endfunction

  task automatic wr(input int idx, input int val);
    map_we = 1'b1;
    map_idx = 4'(idx);
    map_val = 4'(val);
    step();
    map_we = 1'b0;
    if (idx < 12) m[idx] = 4'(val);
  endtask

  task automatic req_chk(input string tag, input logic [11:0] req,
                         input logic [11:0] exp_c, input logic [11:0] exp_p);
    periph_req = req;
    step();
    chk({tag, " chan_gnt"}, chan_gnt, exp_c);
    chk({tag, " periph_gnt"}, periph_gnt, exp_p);
    periph_req = '0;
    step();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] e;
    @(negedge clk);
    do_reset();

    chk("R1 reset chan_gnt", chan_gnt, 12'h000);
    chk("R1 reset periph_gnt", periph_gnt, 12'h000);
    periph_irq = 12'hFFF;
    #1 chk("R1 R8 reset map irq all", irq_out, 12'hFFF);
    periph_irq = 12'h5A3;
    #1 chk("R8 identity irq", irq_out, 12'h5A3);
    periph_irq = '0;

    for (int v = 0; v < 8; v++) begin
      periph_req = VEC[v][24:13];
      bus_busy   = VEC[v][12];
      step();
      chk($sformatf("R2 R5 R6 vec%0d chan_gnt", v), chan_gnt, VEC[v][11:0]);
      chk($sformatf("R7 vec%0d periph_gnt", v), periph_gnt, VEC[v][11:0]);
    end
    periph_req = '0;
    bus_busy = 1'b0;
    step();
    chk("R5 pulse ends", chan_gnt, 12'h000);

    wr(3, 15);
    req_chk("R3 invalid ch3", 12'h008, 12'h000, 12'h000);
    periph_irq = 12'h008;
    #1 chk("R3 invalid irq", irq_out, 12'h000);
    periph_irq = '0;

    wr(2, 5);
    req_chk("R4 dup ch2/ch5", 12'h020, 12'h020, 12'h020);
    wr(7, 5);
    req_chk("R4 dup ch7 wins", 12'h020, 12'h080, 12'h020);
    periph_irq = 12'h020;
    #1 chk("R4 dup irq", irq_out, 12'h080);
    periph_irq = '0;

    do_reset();
    wr(0, 9);
    wr(9, 0);
    req_chk("R2 R7 remap ch0->p9", 12'h600, 12'h001, 12'h200);

    do_reset();
    periph_req = 12'h010;
    map_we = 1'b1; map_idx = 4'd4; map_val = 4'd9;
    step();
    map_we = 1'b0; m[4] = 4'd9;
    chk("R9 old map chan_gnt", chan_gnt, 12'h010);
    chk("R9 old map periph_gnt", periph_gnt, 12'h010);
    step();
    chk("R9 R4 new map no grant", chan_gnt, 12'h000);
    periph_req = '0;

    do_reset();
    wr(14, 0);
    periph_irq = 12'hFFF;
    #1 chk("R9 ignored idx14 irq", irq_out, 12'hFFF);
    periph_irq = '0;
    req_chk("R9 ignored idx14 gnt", 12'h001, 12'h001, 12'h001);

    do_reset();
    for (int k = 0; k < 400; k++) begin
      map_we = ($urandom % 3) == 0;
      map_idx = 4'($urandom);
      map_val = ($urandom % 4 == 0) ? 4'(12 + $urandom % 4) : 4'($urandom % 12);
      periph_req = 12'($urandom);
      periph_irq = 12'($urandom);
      bus_busy = ($urandom % 5) == 0;
      #1 chk("R3 R4 R8 random irq", irq_out, model_irq(periph_irq));
      e = model_gnt(periph_req, bus_busy);
      step();
      chk("R2 R5 R6 random chan_gnt", chan_gnt, e[11:0]);
      chk("R7 random periph_gnt", periph_gnt, e[23:12]);
      if (map_we && map_idx < 4'd12) m[map_idx] = map_val;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule